// File: doc/BRIEF.md
# Configuration Write CRC Accumulator

This block keeps a running 32-bit cyclic redundancy check over a stream of configuration register writes. Each write presents a 5-bit register address together with a 32-bit data word. When the write strobe is high, the block joins the address and the data into a single 37-bit value. It folds that value into the stored checksum in one clock cycle, so a new write can be absorbed on every cycle.

Surrounding logic decides which writes belong to the protected region. It pulses the clear strobe at the start of that region and raises the write strobe for each covered word. At the end, it presents the expected checksum on the compare input. The match output then shows whether the accumulated value agrees with the expected one. The stored checksum is also visible on its own output.

Top module: `cfg_crc_accum`

## Requirements
- R1: The update consumes the 37-bit operand least significant bit first. At each of the 37 steps, the checksum shifts right by one place. When the operand bit differs from checksum bit 0, the reflected constant 0x82F63B78 is also XORed into the shifted value.
- R2: The operand places the data word in bits 31..0 and the register address in bits 36..32.
- R3: When `wr_vld` is high at a rising edge and `crc_clr` is low, `crc_q` shows the updated checksum from that edge onward. This allows one write per cycle, with back-to-back writes chaining.
- R4: A high `rst` or a high `crc_clr` at a rising edge loads zero into the checksum. `crc_clr` wins over a simultaneous `wr_vld`.
- R5: When neither `wr_vld` nor `crc_clr` is high, the checksum holds its value, whatever `wr_addr` and `wr_data` carry.
- R6: `crc_ok` is high exactly when `crc_q` equals `crc_ref`. It follows `crc_ref` within the same cycle.
- R7: Starting from a zero checksum, a single write gives these results: address 0 with data 0 gives 0x00000000; address 0x10 with data 0 gives 0x82F63B78; address 0x1F with data 0xFFFFFFFF gives 0xBF86D4DF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_clr | input | 1 | Load the checksum with zero |
| wr_vld | input | 1 | Absorb the current address and data |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 32 | Data word of the write |
| crc_ref | input | 32 | Expected checksum for comparison |
| crc_q | output | 32 | Registered running checksum |
| crc_ok | output | 1 | High when `crc_q` equals `crc_ref` |

## Verification
The clear strobe and a write strobe can both be high on the same edge, which means a new region starts while a covered word is still arriving. The bench provokes this collision at least once after the checksum is non-zero. It raises both strobes with non-zero address and data. It then requires the checksum to read zero on the following cycle, and requires a later write to chain from zero. A second overlap is the compare input changing in the same cycle as a write lands. That case is judged by checking the match flag against both the correct and a one-bit-off reference right after each update.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OPND_W = ADDR_W + DATA_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h82F63B78;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [OPND_W-1:0] opnd_t;
endpackage

// File: rtl/cfg_crc_fold.sv
module cfg_crc_fold
  import cfg_crc_pkg::*;
#(
  parameter int unsigned CW = CRC_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter logic [CW-1:0] POLY = CRC_POLY
) (
  input  logic [CW-1:0] crc_in,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [CW-1:0] crc_out
);
  localparam int unsigned NB = AW + DW;

  logic [NB-1:0] opnd;
  logic [CW-1:0] stage [0:NB];

  // address sits above the data word
  assign opnd     = {addr, data};
  assign stage[0] = crc_in;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic mix;
    assign mix          = opnd[i] ^ stage[i][0];
    assign stage[i+1]   = (stage[i] >> 1) ^ (mix ? POLY : '0);
  end

  assign crc_out = stage[NB];

  // zero operand into a zero checksum stays zero
  always_comb begin
    if (crc_in == '0 && addr == '0 && data == '0)
      AST_ZERO_FIXED: assert (crc_out == '0); // R7
  end
endmodule

// File: rtl/cfg_crc_state.sv
module cfg_crc_state #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] nxt,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load)  q <= nxt;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load) |=> $stable(q)); // R5
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> q == $past(nxt)); // R3
endmodule

// File: rtl/cfg_crc_cmp.sv
module cfg_crc_cmp #(
  parameter int unsigned CW = 32
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  output logic          eq
);
  logic [CW-1:0] diff;
  assign diff = a ^ b;
  assign eq   = ~|diff;
endmodule

// File: rtl/cfg_crc_accum.sv
module cfg_crc_accum
  import cfg_crc_pkg::*;
#(
  parameter int unsigned CW = CRC_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter logic [CW-1:0] POLY = CRC_POLY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          crc_clr,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] crc_ref,
  output logic [CW-1:0] crc_q,
  output logic          crc_ok
);
  logic [CW-1:0] crc_cur;
  logic [CW-1:0] crc_nxt;

  cfg_crc_fold #(.CW(CW), .AW(AW), .DW(DW), .POLY(POLY)) u_fold (
    .crc_in (crc_cur),
    .addr   (wr_addr),
    .data   (wr_data),
    .crc_out(crc_nxt)
  );

  cfg_crc_state #(.CW(CW)) u_state (
    .clk (clk),
    .rst (rst),
    .clr (crc_clr),
    .load(wr_vld),
    .nxt (crc_nxt),
    .q   (crc_cur)
  );

  cfg_crc_cmp #(.CW(CW)) u_cmp (
    .a (crc_cur),
    .b (crc_ref),
    .eq(crc_ok)
  );

  assign crc_q = crc_cur;

  AST_MATCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_vld && !crc_clr) && crc_ref == $past(crc_nxt)) |-> crc_ok); // R6
endmodule

// File: tb/test_cfg_crc_accum.sv
module test_cfg_crc_accum;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        crc_clr = 1'b0;
  logic        wr_vld = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] crc_ref = '0;
  logic [31:0] crc_q;
  logic        crc_ok;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  cfg_crc_accum i_cfg_crc_accum (
    .clk(clk), .rst(rst), .crc_clr(crc_clr), .wr_vld(wr_vld),
    .wr_addr(wr_addr), .wr_data(wr_data), .crc_ref(crc_ref),
    .crc_q(crc_q), .crc_ok(crc_ok)
  );

  // bitwise reference per R1/R2
  function automatic logic [31:0] ref_upd(logic [31:0] c, logic [4:0] a, logic [31:0] d);
    logic [36:0] v;
    v = {a, d};
    for (int k = 0; k < 37; k++) begin
      if (v[k] != c[0]) c = (c >> 1) ^ 32'h82F63B78;
      else              c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive at negedge, edge happens, sample at following negedge
  task automatic cyc(logic c, logic v, logic [4:0] a, logic [31:0] d);
    crc_clr = c; wr_vld = v; wr_addr = a; wr_data = d;
    if (c) model = '0;
    else if (v) model = ref_upd(model, a, d);
    @(negedge clk);
    crc_clr = 1'b0; wr_vld = 1'b0;
  endtask

  task automatic match_chk(string req);
    crc_ref = model; #1;
    chk(req, {31'd0, crc_ok}, 32'd1);
    crc_ref = model ^ 32'h0000_0100; #1;
    chk(req, {31'd0, crc_ok}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R4 reset", crc_q, 32'h0);
    // R7 fixed vectors
    cyc(1'b0, 1'b1, 5'h00, 32'h0);
    chk("R7 zero", crc_q, 32'h0);
    cyc(1'b0, 1'b1, 5'h10, 32'h0);
    chk("R7 addr10", crc_q, 32'h82F63B78);
    cyc(1'b1, 1'b0, 5'h0, 32'h0);
    cyc(1'b0, 1'b1, 5'h1F, 32'hFFFFFFFF);
    chk("R7 ones", crc_q, 32'hBF86D4DF);
    // R1/R2 sweep: every address with every single data bit, from zero
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 33; b++) begin
        cyc(1'b1, 1'b0, 5'h0, 32'h0);
        cyc(1'b0, 1'b1, a[4:0], (b == 32) ? 32'h0 : (32'h1 << b));
        chk("R1 R2 single", crc_q, model);
      end
    end
    // R3 back-to-back chains with varied patterns
    cyc(1'b1, 1'b0, 5'h0, 32'h0);
    for (int i = 0; i < 400; i++) begin
      cyc(1'b0, 1'b1, i[4:0] ^ 5'h15, (i * 32'h9E3779B1) ^ 32'hA5A5_0F0F);
      chk("R3 chain", crc_q, model);
      if (i % 37 == 0) match_chk("R6 match");
    end
    // R5 idle cycles with changing bus values
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0, 1'b0, i[4:0], 32'hDEAD_0000 + i);
      chk("R5 hold", crc_q, model);
    end
    // R4 clear beats simultaneous write
    cyc(1'b1, 1'b1, 5'h0B, 32'h1234_5678);
    chk("R4 clr wins", crc_q, 32'h0);
    cyc(1'b0, 1'b1, 5'h03, 32'hCAFE_F00D);
    chk("R3 after clr", crc_q, model);
    match_chk("R6 after clr");
    // R4 reset mid-stream
    rst = 1'b1; @(negedge clk); rst = 1'b0; model = '0;
    chk("R4 reset mid", crc_q, 32'h0);
    match_chk("R6 zero");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule